// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block reads one page from a NAND flash device by driving the device's pins itself. A single `start_i` pulse latches a 16-bit column, a 24-bit row and a byte count. The block then issues the read-setup command (00h) and five address bytes: the column low and high bytes, then the row low, middle and high bytes. It follows them with the read-confirm command (30h). Each command or address byte is written with its own setup, write-enable low and hold phases. Every phase is a whole number of clocks set by a parameter.

After the confirm command the block waits a fixed settling time for the device to report busy. It then watches the active-high ready line. Chip enable stays low for the whole busy period, because a device that needs chip enable held would otherwise go to standby. Once ready is seen, the block waits a programmable ready-to-read delay. It then clocks out the requested number of words with read-enable pulses, and captures each word at the end of its low phase. If ready does not return within a set number of clocks, the read is abandoned and finishes with an error flag.

Top module: `nand_page_reader`

## Requirements
- R1: Out of reset and while idle, chip enable, write enable and read enable are high, the two latch-enable lines are low, the I/O bus is not driven (`nand_io_oe_o` low), and `data_valid_o`, `done_o` and `err_o` are low.
- R2: A start writes seven bytes in this order: 00h, column[7:0], column[15:8], row[7:0], row[15:8], row[23:16], 30h. The command-latch line is high for bytes 0 and 6 only, the address-latch line is high for bytes 1 to 5 only, and the two are never high together.
- R3: Each written byte takes `T_SU` clocks with write enable high, then `T_WP` clocks with write enable low, then `T_WH` clocks with write enable high. During all three phases the byte, the latch lines and the bus enable do not change. Write enable and read enable are never low together.
- R4: During command and address bytes, I/O bits above bit 7 are driven as zero.
- R5: Chip enable goes low in the first clock after start and stays low until the done cycle, including the busy wait. It rises only in the done cycle.
- R6: After the 30h byte the block spends `T_WB` clocks without sampling ready, and then waits for `nand_rdy_i` to be high. Read enable is never low while ready is low. The first read-enable low comes `T_RR` clocks after the clock edge at which ready was seen high.
- R7: Each word read has `T_RP` clocks of read enable low and `T_REH` clocks of read enable high. The bus value of the last low clock is shown on `data_o`, with `data_valid_o` high for exactly the first high clock. There are exactly `nbytes_i` such pulses, and word k comes from column address col+k.
- R8: A byte count of zero gives no read-enable pulse, and the done cycle follows directly after the ready-to-read delay.
- R9: `done_o` is high for a single clock at the end of every read, and the block is idle in the next clock.
- R10: If ready is still low in the last of `TMO` waiting clocks, the read ends with no read-enable pulse and `err_o` high together with `done_o`. A ready seen in that last clock wins over the timeout.
- R11: A start pulse while a read is in progress is ignored, and the latched addresses and count do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a page read (taken only when idle) |
| col_i | input | 16 | Column address |
| row_i | input | 24 | Row (page) address |
| nbytes_i | input | CNT_W | Number of words to read |
| nand_rdy_i | input | 1 | Device ready, high = ready, low = busy |
| nand_io_i | input | DW | Data bus from device |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write enable, active low |
| nand_re_no | output | 1 | Read enable, active low |
| nand_io_o | output | DW | Data bus to device |
| nand_io_oe_o | output | 1 | Drive enable for nand_io_o |
| data_o | output | DW | Captured read word |
| data_valid_o | output | 1 | data_o holds a new word |
| done_o | output | 1 | Single-clock end-of-read pulse |
| err_o | output | 1 | Ready timeout, valid with done_o |

## Verification
The bench runs a 16-bit device model that records the latched command and address bytes, goes busy on the confirm command, and returns a pattern computed from the row and column it decoded. A cycle-exact expected pin trace is compared with the outputs on every clock. Reads of 4, 7, 1 and 20 words with different addresses show whether byte order and data addressing are right. Busy periods shorter than the settling time and of medium length show whether the ready wait is placed correctly. A zero-length read and a start pulse given mid-read separate the skip path from the ignore path. Busy lengths that end in the last waiting clock, and one clock later, mark the exact timeout boundary.

// File: rtl/nrd_pkg.sv
package nrd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_WSU, ST_WLO, ST_WHD, ST_WB, ST_WAIT,
    ST_RR, ST_RLO, ST_RHI, ST_FIN
  } nrd_state_e;

  localparam logic [7:0] CMD_SETUP   = 8'h00;
  localparam logic [7:0] CMD_CONFIRM = 8'h30;
  localparam int unsigned N_WR       = 7;
endpackage

// File: rtl/nrd_timer.sv
module nrd_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nrd_cycle_mux.sv
module nrd_cycle_mux
  import nrd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [2:0]    idx_i,
  input  logic [15:0]   col_i,
  input  logic [23:0]   row_i,
  output logic [DW-1:0] io_o,
  output logic          cle_o,
  output logic          ale_o
);
  logic [7:0] byte_w;

  always_comb begin
    cle_o  = 1'b0;
    ale_o  = 1'b1;
    byte_w = 8'h00;
    unique case (idx_i)
      3'd0: begin byte_w = CMD_SETUP;   cle_o = 1'b1; ale_o = 1'b0; end
      3'd1: byte_w = col_i[7:0];
      3'd2: byte_w = col_i[15:8];
      3'd3: byte_w = row_i[7:0];
      3'd4: byte_w = row_i[15:8];
      3'd5: byte_w = row_i[23:16];
      default: begin byte_w = CMD_CONFIRM; cle_o = 1'b1; ale_o = 1'b0; end
    endcase
  end

  // commands and addresses use the low byte only
  generate
    if (DW > 8) begin : g_wide
      assign io_o = {{(DW-8){1'b0}}, byte_w};
    end else begin : g_narrow
      assign io_o = byte_w;
    end
  endgenerate
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import nrd_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 12,
  parameter int T_SU  = 3,
  parameter int T_WP  = 4,
  parameter int T_WH  = 2,
  parameter int T_WB  = 3,
  parameter int T_RR  = 5,
  parameter int T_RP  = 5,
  parameter int T_REH = 3,
  parameter int TMO   = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [15:0]      col_i,
  input  logic [23:0]      row_i,
  input  logic [CNT_W-1:0] nbytes_i,
  input  logic             nand_rdy_i,
  input  logic [DW-1:0]    nand_io_i,
  output logic             nand_ce_no,
  output logic             nand_cle_o,
  output logic             nand_ale_o,
  output logic             nand_we_no,
  output logic             nand_re_no,
  output logic [DW-1:0]    nand_io_o,
  output logic             nand_io_oe_o,
  output logic [DW-1:0]    data_o,
  output logic             data_valid_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int TMAX = (TMO > 64) ? TMO : 64;
  localparam int TW   = $clog2(TMAX + 1);

  nrd_state_e       state_q, state_d;
  logic [2:0]       idx_q;
  logic [15:0]      col_q;
  logic [23:0]      row_q;
  logic [CNT_W-1:0] n_q, rem_q;
  logic             err_q, dv_q;
  logic [DW-1:0]    dq_q;
  logic             tmr_load, tmr_zero;
  logic [TW-1:0]    tmr_val;
  logic [DW-1:0]    mux_io;
  logic             mux_cle, mux_ale;
  logic             wr_phase, timeout_w, capture_w;

  nrd_timer #(.W(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  nrd_cycle_mux #(.DW(DW)) u_mux (
    .idx_i (idx_q),
    .col_i (col_q),
    .row_i (row_q),
    .io_o  (mux_io),
    .cle_o (mux_cle),
    .ale_o (mux_ale)
  );

  always_comb begin
    state_d   = state_q;
    timeout_w = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_WSU;
      ST_WSU:  if (tmr_zero) state_d = ST_WLO;
      ST_WLO:  if (tmr_zero) state_d = ST_WHD;
      ST_WHD:  if (tmr_zero) state_d = (idx_q == 3'(N_WR - 1)) ? ST_WB : ST_WSU;
      ST_WB:   if (tmr_zero) state_d = ST_WAIT;
      ST_WAIT: begin
        if (nand_rdy_i) state_d = ST_RR;
        else if (tmr_zero) begin
          state_d   = ST_FIN;
          timeout_w = 1'b1;
        end
      end
      ST_RR:   if (tmr_zero) state_d = (n_q == '0) ? ST_FIN : ST_RLO;
      ST_RLO:  if (tmr_zero) state_d = ST_RHI;
      ST_RHI:  if (tmr_zero) state_d = (rem_q == '0) ? ST_FIN : ST_RLO;
      default: state_d = ST_IDLE;
    endcase
  end

  // every state change restarts the phase timer with the new phase length
  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      ST_WSU:  tmr_val = TW'(T_SU - 1);
      ST_WLO:  tmr_val = TW'(T_WP - 1);
      ST_WHD:  tmr_val = TW'(T_WH - 1);
      ST_WB:   tmr_val = TW'(T_WB - 1);
      ST_WAIT: tmr_val = TW'(TMO - 1);
      ST_RR:   tmr_val = TW'(T_RR - 1);
      ST_RLO:  tmr_val = TW'(T_RP - 1);
      ST_RHI:  tmr_val = TW'(T_REH - 1);
      default: tmr_val = '0;
    endcase
  end

  assign capture_w = (state_q == ST_RLO) && tmr_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      col_q   <= '0;
      row_q   <= '0;
      n_q     <= '0;
      rem_q   <= '0;
      err_q   <= 1'b0;
      dv_q    <= 1'b0;
      dq_q    <= '0;
    end else begin
      state_q <= state_d;
      dv_q    <= capture_w;
      if (state_q == ST_IDLE && start_i) begin
        idx_q <= '0;
        col_q <= col_i;
        row_q <= row_i;
        n_q   <= nbytes_i;
        rem_q <= nbytes_i;
        err_q <= 1'b0;
      end
      if (state_q == ST_WHD && tmr_zero) idx_q <= idx_q + 1'b1;
      if (timeout_w) err_q <= 1'b1;
      if (capture_w) begin
        dq_q  <= nand_io_i;
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  assign wr_phase     = (state_q == ST_WSU) || (state_q == ST_WLO) || (state_q == ST_WHD);
  assign nand_ce_no   = (state_q == ST_IDLE) || (state_q == ST_FIN);
  assign nand_cle_o   = wr_phase && mux_cle;
  assign nand_ale_o   = wr_phase && mux_ale;
  assign nand_we_no   = (state_q != ST_WLO);
  assign nand_re_no   = (state_q != ST_RLO);
  assign nand_io_o    = wr_phase ? mux_io : '0;
  assign nand_io_oe_o = wr_phase;
  assign data_o       = dq_q;
  assign data_valid_o = dv_q;
  assign done_o       = (state_q == ST_FIN);
  assign err_o        = (state_q == ST_FIN) && err_q;
endmodule

// File: rtl/nand_page_reader_chk.sv
module nand_page_reader_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          nand_ce_no,
  input logic          nand_cle_o,
  input logic          nand_ale_o,
  input logic          nand_we_no,
  input logic          nand_re_no,
  input logic [DW-1:0] nand_io_o,
  input logic          data_valid_o,
  input logic          done_o,
  input logic          err_o
);
  p_latch_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));

  p_we_low_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no && $past(!nand_we_no)) |->
      ($stable(nand_io_o) && $stable(nand_cle_o) && $stable(nand_ale_o)));

  p_we_re_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no));

  p_ce_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nand_ce_no) |-> done_o);

  p_valid_after_re_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> ($past(!nand_re_no) && nand_re_no));

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_err_with_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
endmodule

bind nand_page_reader nand_page_reader_chk #(.DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .nand_ce_no   (nand_ce_no),
  .nand_cle_o   (nand_cle_o),
  .nand_ale_o   (nand_ale_o),
  .nand_we_no   (nand_we_no),
  .nand_re_no   (nand_re_no),
  .nand_io_o    (nand_io_o),
  .data_valid_o (data_valid_o),
  .done_o       (done_o),
  .err_o        (err_o)
);

// File: tb/nand_page_reader_bench.sv
module nand_page_reader_bench;
  localparam int DW = 16, CNT_W = 8;
  localparam int T_SU = 3, T_WP = 4, T_WH = 2, T_WB = 3;
  localparam int T_RR = 5, T_RP = 5, T_REH = 3, TMO = 200;

  typedef struct packed {
    logic ce_n, cle, ale, we_n, re_n, oe;
    logic [15:0] io;
    logic dv;
    logic [15:0] dat;
    logic done, err;
  } vec_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [15:0] col_i = '0;
  logic [23:0] row_i = '0;
  logic [CNT_W-1:0] nbytes_i = '0;
  logic nand_rdy_i = 1'b1;
  logic [DW-1:0] nand_io_i;
  logic nand_ce_no, nand_cle_o, nand_ale_o, nand_we_no, nand_re_no, nand_io_oe_o;
  logic [DW-1:0] nand_io_o, data_o;
  logic data_valid_o, done_o, err_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  vec_t q[$];
  string scen = "reset R1";

  always #2 clk_i = ~clk_i;

  nand_page_reader #(
    .DW(DW), .CNT_W(CNT_W), .T_SU(T_SU), .T_WP(T_WP), .T_WH(T_WH), .T_WB(T_WB),
    .T_RR(T_RR), .T_RP(T_RP), .T_REH(T_REH), .TMO(TMO)
  ) u_nand_page_reader (
    .clk_i, .rst_ni, .start_i, .col_i, .row_i, .nbytes_i, .nand_rdy_i, .nand_io_i,
    .nand_ce_no, .nand_cle_o, .nand_ale_o, .nand_we_no, .nand_re_no, .nand_io_o,
    .nand_io_oe_o, .data_o, .data_valid_o, .done_o, .err_o
  );

  function automatic logic [15:0] pat(input logic [23:0] r, input logic [15:0] a);
    return {a[7:0] ^ r[23:16], a[15:8] + a[7:0] + r[7:0]};
  endfunction

  function automatic vec_t mk(logic ce_n, logic cle, logic ale, logic we_n, logic re_n,
                              logic oe, logic [15:0] io, logic dv, logic [15:0] dat,
                              logic done, logic err);
    vec_t v;
    v.ce_n = ce_n; v.cle = cle; v.ale = ale; v.we_n = we_n; v.re_n = re_n; v.oe = oe;
    v.io = oe ? io : 16'h0; v.dv = dv; v.dat = dv ? dat : 16'h0; v.done = done; v.err = err;
    return v;
  endfunction

  function automatic string tag_of(vec_t a, vec_t e);
    if (a.io[15:8] != e.io[15:8]) return "R4";
    if (a.cle != e.cle || a.ale != e.ale || a.io != e.io) return "R2";
    if (a.we_n != e.we_n || a.oe != e.oe) return "R3";
    if (a.ce_n != e.ce_n) return "R5";
    if (a.re_n != e.re_n) return "R6";
    if (a.dv != e.dv || a.dat != e.dat) return "R7";
    if (a.err != e.err) return "R10";
    return "R9";
  endfunction

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // ---------------- behavioural device model ----------------
  logic [7:0] lat_b [0:6];
  logic       lat_c [0:6];
  logic       lat_a [0:6];
  int lat_n = 0, busy_len = 1, busy_cnt = 0, m_k = 0;
  logic [15:0] m_col = '0;
  logic [23:0] m_row = '0;
  logic prev_we = 1'b1, prev_re = 1'b1;

  assign nand_io_i = !nand_re_no ? pat(m_row, m_col + 16'(m_k)) : '0;

  always @(negedge clk_i) begin
    if (prev_we == 1'b0 && nand_we_no == 1'b1) begin
      if (nand_cle_o && nand_io_o[7:0] == 8'h00) lat_n = 0;
      if (lat_n < 7) begin
        lat_b[lat_n] = nand_io_o[7:0];
        lat_c[lat_n] = nand_cle_o;
        lat_a[lat_n] = nand_ale_o;
        lat_n++;
      end
      if (nand_cle_o && nand_io_o[7:0] == 8'h30) begin
        m_col = {lat_b[2], lat_b[1]};
        m_row = {lat_b[5], lat_b[4], lat_b[3]};
        m_k = 0;
        busy_cnt = busy_len;
        nand_rdy_i = 1'b0;
      end
    end else if (busy_cnt > 0) begin
      busy_cnt--;
      if (busy_cnt == 0) nand_rdy_i = 1'b1;
    end
    if (prev_re == 1'b0 && nand_re_no == 1'b1) m_k++;
    if (!nand_re_no && !nand_rdy_i) begin
      n_chk++; n_fail++;
      $display("FAIL R6 (%s): read enable low while busy, actual re_n=0 expected 1", scen);
    end
    prev_we = nand_we_no;
    prev_re = nand_re_no;
  end

  // ---------------- per-clock comparison ----------------
  always @(negedge clk_i) begin
    vec_t act, exp;
    cyc++;
    act = mk(nand_ce_no, nand_cle_o, nand_ale_o, nand_we_no, nand_re_no, nand_io_oe_o,
             nand_io_o, data_valid_o, data_o, done_o, err_o);
    if (q.size() > 0) exp = q.pop_front();
    else exp = mk(1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);  // idle, R1
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (%s) cycle %0d: actual %h expected %h",
               (q.size() == 0 && exp.ce_n && !exp.done) ? "R1" : tag_of(act, exp),
               scen, cyc, act, exp);
    end
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (%s): actual cycle %0d expected < 150000", scen, cyc);
      report();
    end
  end

  task automatic push(vec_t v, int cnt);
    for (int i = 0; i < cnt; i++) q.push_back(v);
  endtask

  task automatic build(logic [15:0] col, logic [23:0] row, int n, int busy);
    logic [7:0] b [0:6];
    int kr;
    b[0] = 8'h00; b[1] = col[7:0]; b[2] = col[15:8];
    b[3] = row[7:0]; b[4] = row[15:8]; b[5] = row[23:16]; b[6] = 8'h30;
    for (int i = 0; i < 7; i++) begin
      logic c;
      c = (i == 0 || i == 6);
      push(mk(0, c, !c, 1, 1, 1, {8'h00, b[i]}, 0, 0, 0, 0), T_SU);
      push(mk(0, c, !c, 0, 1, 1, {8'h00, b[i]}, 0, 0, 0, 0), T_WP);
      push(mk(0, c, !c, 1, 1, 1, {8'h00, b[i]}, 0, 0, 0, 0), T_WH);
    end
    push(mk(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0), T_WB);
    kr = busy - T_WH - T_WB;
    if (kr < 0) kr = 0;
    if (kr <= TMO - 1) begin
      push(mk(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0), kr + 1 + T_RR);
      for (int k = 0; k < n; k++) begin
        push(mk(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0), T_RP);
        push(mk(0, 0, 0, 1, 1, 0, 0, 1, pat(row, col + 16'(k)), 0, 0), 1);
        push(mk(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0), T_REH - 1);
      end
      push(mk(1, 0, 0, 1, 1, 0, 0, 0, 0, 1, 0), 1);
    end else begin
      push(mk(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0), TMO);
      push(mk(1, 0, 0, 1, 1, 0, 0, 0, 0, 1, 1), 1);  // R10 timeout
    end
  endtask

  task automatic run_op(string nm, logic [15:0] col, logic [23:0] row, int n, int busy,
                        bit mid);
    logic [7:0] eb [0:6];
    @(negedge clk_i); #1;
    scen = nm;
    busy_len = busy;
    col_i = col; row_i = row; nbytes_i = CNT_W'(n);
    start_i = 1'b1;
    build(col, row, n, busy);
    @(negedge clk_i); #1;
    start_i = 1'b0;
    if (mid) begin  // R11: second start mid-read must be ignored
      repeat (6) @(negedge clk_i);
      #1;
      col_i = ~col; row_i = ~row; nbytes_i = 8'd3; start_i = 1'b1;
      @(negedge clk_i); #1;
      start_i = 1'b0;
    end
    while (q.size() != 0) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
    // R2: bytes latched by the device model, in order
    eb[0] = 8'h00; eb[1] = col[7:0]; eb[2] = col[15:8];
    eb[3] = row[7:0]; eb[4] = row[15:8]; eb[5] = row[23:16]; eb[6] = 8'h30;
    n_chk++;
    if (lat_n != 7) begin
      n_fail++;
      $display("FAIL R2 (%s): latched count actual %0d expected 7", nm, lat_n);
    end
    for (int i = 0; i < 7; i++) begin
      n_chk++;
      if (lat_b[i] !== eb[i] || lat_c[i] !== (i == 0 || i == 6) || lat_a[i] !== !(i == 0 || i == 6)) begin
        n_fail++;
        $display("FAIL R2 (%s): byte %0d actual %h/%b%b expected %h/%b%b", nm, i,
                 lat_b[i], lat_c[i], lat_a[i], eb[i], (i == 0 || i == 6), !(i == 0 || i == 6));
      end
    end
    while (!nand_rdy_i) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    #1 rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    run_op("R7 four words", 16'h0000, 24'h000000, 4, 20, 0);
    run_op("R11 mid-read start", 16'h1A2B, 24'hC3D4E5, 7, 60, 1);
    run_op("R8 zero length", 16'h0800, 24'h012345, 0, 10, 0);
    run_op("R6 short busy", 16'h00F0, 24'h00A001, 2, 1, 0);
    run_op("R10 timeout", 16'h4321, 24'h765432, 3, 500, 0);
    run_op("R10 ready in last wait clock", 16'h0102, 24'h030405, 1, TMO - 1 + T_WH + T_WB, 0);
    run_op("R10 one clock past limit", 16'h0102, 24'h030405, 1, TMO + T_WH + T_WB, 0);
    run_op("R7 long read", 16'hFFF8, 24'hFFFFFF, 20, 33, 0);
    report();
  end
endmodule